// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block generates the two lowest word-address bits for a memory burst of four beats. When either of two address strobes is seen on a rising clock edge, the supplied two-bit start address is captured and becomes the current burst address. After that, each rising edge with the advance input high moves the burst to its next beat. Edges with neither a strobe nor an advance leave the address unchanged. Any higher address bits are handled outside the block and pass beside it unchanged.

A static order-select input chooses between two beat orders. In the interleaved order, beat k uses start XOR k. In the linear order, beat k uses (start + k) mod 4. The selection is expected to be tied high, which gives the interleaved order, when the system leaves it undriven. A wrap flag marks the fourth beat of a burst, so that the next advance returns to the start address.

Top module: `burst_seq`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, `addr_o` is 0 and `wrap_o` is 0.
- R2: A clock edge with `stb_proc_i` or `stb_ctrl_i` high loads `addr_i`. From the next cycle, `addr_o` equals that value and `wrap_o` is 0.
- R3: On a clock edge with both strobes low and `adv_i` low, `addr_o` and `wrap_o` do not change, provided `interleave_i` is held.
- R4: With `interleave_i` = 0 (linear order), `addr_o` after k advances since the last load is (start + k) mod 4.
- R5: With `interleave_i` = 1 (interleaved order), `addr_o` after k advances since the last load is start XOR k.
- R6: After four advances, `addr_o` returns to the start address, and the beat order then repeats.
- R7: When a strobe and `adv_i` are high on the same edge, the strobe takes priority and `addr_i` is loaded.
- R8: `wrap_o` is 1 exactly when the number of advances since the last load is 3 mod 4, which is the fourth beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| interleave_i | input | 1 | Beat order: 1 selects interleaved, 0 selects linear; tie high when undriven |
| stb_proc_i | input | 1 | Burst start strobe from the processor side |
| stb_ctrl_i | input | 1 | Burst start strobe from the cache-controller side |
| adv_i | input | 1 | Advance to the next beat |
| addr_i | input | 2 | Start address loaded on a strobe |
| addr_o | output | 2 | Current burst address bits |
| wrap_o | output | 1 | High on the fourth beat of the burst |

## Verification
The assertions assume that `interleave_i` changes only on a cycle that also loads a new burst. The hold check in particular is qualified on that input being stable. The stimulus changes the order selection only together with a strobe. Every other input may change freely each cycle, including strobes and advances arriving together.

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             interleave_i,
  input  logic             stb_proc_i,
  input  logic             stb_ctrl_i,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] addr_i,
  output logic [CNT_W-1:0] addr_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] LAST = '1;

  logic [CNT_W-1:0] start_q;
  logic [CNT_W-1:0] beat_q;
  logic             load;

  assign load = stb_proc_i | stb_ctrl_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      beat_q  <= '0;
    end else if (load) begin
      start_q <= addr_i;
      beat_q  <= '0;
    end else if (adv_i) begin
      beat_q  <= beat_q + 1'b1;
    end
  end

  assign addr_o = interleave_i ? (start_q ^ beat_q) : (start_q + beat_q);
  assign wrap_o = (beat_q == LAST);
endmodule

module burst_seq_chk #(
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             interleave_i,
  input logic             stb_proc_i,
  input logic             stb_ctrl_i,
  input logic             adv_i,
  input logic [CNT_W-1:0] addr_i,
  input logic [CNT_W-1:0] addr_o,
  input logic             wrap_o
);
  logic [CNT_W-1:0] m_start;
  logic [CNT_W-1:0] m_cnt;
  logic             stb;

  assign stb = stb_proc_i | stb_ctrl_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_start <= '0;
      m_cnt   <= '0;
    end else if (stb) begin
      m_start <= addr_i;
      m_cnt   <= '0;
    end else if (adv_i) begin
      m_cnt   <= m_cnt + 1'b1;
    end
  end

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> (addr_o == $past(addr_i)) && !wrap_o);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb && !adv_i) |=> ($stable(interleave_i) -> ($stable(addr_o) && $stable(wrap_o))));

  // R4
  linear_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !interleave_i |-> addr_o == CNT_W'(m_start + m_cnt));

  // R5
  interleave_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    interleave_i |-> addr_o == (m_start ^ m_cnt));

  // R7
  strobe_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && adv_i) |=> addr_o == $past(addr_i));

  // R8
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o == (m_cnt == '1));
endmodule

bind burst_seq burst_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .interleave_i(interleave_i),
  .stb_proc_i(stb_proc_i), .stb_ctrl_i(stb_ctrl_i), .adv_i(adv_i),
  .addr_i(addr_i), .addr_o(addr_o), .wrap_o(wrap_o)
);

// File: tb/tb_burst_seq.sv
module tb_burst_seq;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       interleave_i, stb_proc_i, stb_ctrl_i, adv_i;
  logic [1:0] addr_i;
  logic [1:0] addr_o;
  logic       wrap_o;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  burst_seq dut (
    .clk(clk), .rst_n(rst_n), .interleave_i(interleave_i),
    .stb_proc_i(stb_proc_i), .stb_ctrl_i(stb_ctrl_i), .adv_i(adv_i),
    .addr_i(addr_i), .addr_o(addr_o), .wrap_o(wrap_o)
  );

  // {interleave, stb_proc, stb_ctrl, adv, addr[1:0], exp_addr[1:0], exp_wrap}
  localparam int NV = 14;
  localparam logic [8:0] VEC [NV] = '{
    {4'b1100, 2'd2, 2'd2, 1'b0},  // R2 processor strobe, start 2
    {4'b1001, 2'd0, 2'd3, 1'b0},  // R5 2^1
    {4'b1001, 2'd0, 2'd0, 1'b0},  // R5 2^2
    {4'b1000, 2'd0, 2'd0, 1'b0},  // R3 idle holds
    {4'b1001, 2'd0, 2'd1, 1'b1},  // R5 R8 2^3, fourth beat
    {4'b1001, 2'd0, 2'd2, 1'b0},  // R6 back to start
    {4'b1010, 2'd1, 2'd1, 1'b0},  // R2 controller strobe, start 1
    {4'b1101, 2'd3, 2'd3, 1'b0},  // R7 strobe beats advance
    {4'b0010, 2'd3, 2'd3, 1'b0},  // R2 linear, start 3
    {4'b0001, 2'd0, 2'd0, 1'b0},  // R4 3+1
    {4'b0001, 2'd0, 2'd1, 1'b0},  // R4 3+2
    {4'b0001, 2'd0, 2'd2, 1'b1},  // R4 R8 3+3
    {4'b0001, 2'd0, 2'd3, 1'b0},  // R6 linear wrap
    {4'b0001, 2'd0, 2'd0, 1'b0}   // R4 repeats
  };

  task automatic check(input string req, input logic [1:0] act_a, input logic act_w,
                       input logic [1:0] exp_a, input logic exp_w);
    tests++;
    if (act_a !== exp_a || act_w !== exp_w) begin
      fails++;
      $display("FAIL %s: addr=%0d wrap=%0d expected addr=%0d wrap=%0d",
               req, act_a, act_w, exp_a, exp_w);
    end
  endtask

  task automatic step(input logic m, input logic sp, input logic sc, input logic a,
                      input logic [1:0] ad);
    interleave_i = m; stb_proc_i = sp; stb_ctrl_i = sc; adv_i = a; addr_i = ad;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    fails++;
    tests++;
    $display("FAIL watchdog: addr=%0d wrap=%0d expected run to finish", addr_o, wrap_o);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    interleave_i = 1'b1; stb_proc_i = 1'b0; stb_ctrl_i = 1'b0; adv_i = 1'b1; addr_i = 2'd3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 in reset", addr_o, wrap_o, 2'd0, 1'b0);
    rst_n = 1'b1;
    step(1'b1, 1'b0, 1'b0, 1'b0, 2'd0);
    check("R1 after release", addr_o, wrap_o, 2'd0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4:3]);
      check($sformatf("vector %0d (R2,R3,R4,R5,R6,R7,R8)", i),
            addr_o, wrap_o, VEC[i][2:1], VEC[i][0]);
    end

    // R3: several idle cycles in linear mode keep the beat
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b0, 1'b0, 1'b0, 2'd2);
      check("R3 idle hold", addr_o, wrap_o, 2'd0, 1'b0);
    end

    // R6 R8: full interleaved lap from start 0, plus one more beat
    step(1'b1, 1'b1, 1'b1, 1'b0, 2'd0);
    check("R2 both strobes", addr_o, wrap_o, 2'd0, 1'b0);
    for (int k = 1; k <= 5; k++) begin
      step(1'b1, 1'b0, 1'b0, 1'b1, 2'd1);
      check("R5 R6 R8 lap", addr_o, wrap_o, 2'(k % 4), (k % 4) == 3);
    end

    // R1: reset mid-burst clears the state
    step(1'b1, 1'b0, 1'b0, 1'b1, 2'd0);
    rst_n = 1'b0;
    step(1'b1, 1'b0, 1'b0, 1'b1, 2'd0);
    check("R1 mid-run reset", addr_o, wrap_o, 2'd0, 1'b0);
    rst_n = 1'b1;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule